// File: doc/BRIEF.md
# Flash Program Write Buffer

This block gathers the data words of a buffered flash program operation and then writes them into the array in one step. A setup strobe carries the length count of the operation. It clears the buffer and arms it for a new fill. Each following data write brings a word address, a 32-bit data word and four byte enables. The first write after setup fixes the base address. Every later write is placed at its word offset from that base. Each write is answered one cycle later with an acknowledge. An end flag comes with it when the write was not stored, either because the buffer had already reached its length or because the address fell outside the window the buffer can cover.

A commit strobe moves the gathered data into a simple on-chip array model. The array is split into erase blocks of a power-of-two size, and each block has one lock bit. If the block that holds the base address is locked, the commit is refused and the array is left as it was. Otherwise the first bytes-written bytes of the buffer are copied to the array, starting at the base. A registered read port returns array words, so the result of a program can be observed. All addresses on the ports are word addresses (byte address divided by 4).

Top module: `flash_wrbuf`

## Requirements
- R1: After reset the buffer length and the bytes-written count are both zero, so a data write is answered with wr_end = 1. Every array word reads 0xFFFFFFFF and no block is locked.
- R2: Setup sets the buffer length in bytes to (setup_count + 1) * 4. A result above MAX_BYTES (64 by default) is clamped to MAX_BYTES.
- R3: Setup sets every buffer byte to zero and clears the bytes-written count.
- R4: When the bytes-written count is zero, a data write is stored at buffer word 0 and its address becomes the base. Every data write gets wr_ack = 1 exactly one cycle after wr_valid, and wr_ack is 0 in any other cycle.
- R5: A later write is stored at buffer word (wr_waddr - base). Only the bytes whose wr_be bit is 1 are replaced (bit n selects data bits 8n+7..8n), and the other bytes keep their value. Each stored write adds 4 to the bytes-written count and is answered with wr_end = 0.
- R6: Once the bytes-written count has reached the buffer length, a data write is not stored and is answered with wr_end = 1.
- R7: When the count is nonzero, a write with an address below the base, or with an offset from the base of MAX_BYTES/4 words or more, is not stored. It does not change the count and is answered with wr_end = 1.
- R8: commit_done is 1 exactly one cycle after commit_valid and 0 otherwise. If the lock bit of block (base / (BLOCK_BYTES/4)) is set, commit_ok is 0 and the array is unchanged.
- R9: On an unlocked commit, commit_ok is 1. Buffer word i is written to array word base + i for every i with 4*i below the bytes-written count, and words that would fall past the array end are skipped. The buffer and the count keep their values.
- R10: With lock_we = 1, the lock bit of block lock_blk is set to lock_val.
- R11: rd_data gives the array word at rd_waddr as it was at the previous clock edge, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | Start a new fill with the given count |
| setup_count | input | CNT_W | Length count, length = (count+1)*4 bytes |
| wr_valid | input | 1 | Data write strobe |
| wr_waddr | input | WAW | Word address of the data write |
| wr_data | input | 32 | Data word |
| wr_be | input | 4 | Byte enables of the data word |
| wr_ack | output | 1 | Write answered (one cycle after wr_valid) |
| wr_end | output | 1 | Write was not stored; fill is over |
| commit_valid | input | 1 | Copy the buffer into the array |
| commit_done | output | 1 | Commit answered (one cycle after commit_valid) |
| commit_ok | output | 1 | Commit was performed (block not locked) |
| lock_we | input | 1 | Lock bit write strobe |
| lock_blk | input | BLK_W | Erase block whose lock bit is written |
| lock_val | input | 1 | New lock bit value |
| rd_waddr | input | WAW | Array read word address |
| rd_data | output | 32 | Array word, registered |

## Verification
wr_ack and wr_end are registered at the clock edge that samples wr_valid. commit_done and commit_ok are registered in the same way at the edge that samples commit_valid, and that same edge updates the array. An array word appears on rd_data one edge after its address is sampled, so the earliest read that shows a commit has its address sampled on the edge after the commit edge. The bench drives every strobe for a single cycle from the falling edge and checks the answers on the next falling edge, after exactly one rising edge. Array reads are issued only once the commit answer has been checked, and each read is compared one falling edge after its address was driven.

// File: rtl/flash_wrbuf_pkg.sv
// Shared constants and types of the flash write buffer.
// Assumes a 32-bit data word split into four byte lanes.
package flash_wrbuf_pkg;
    localparam int UNIT_BYTES = 4;
    localparam int DATA_W     = 8 * UNIT_BYTES;

    // Outcome of one data write into the buffer
    typedef enum logic [1:0] {
        WR_STORED = 2'd0,
        WR_FULL   = 2'd1,
        WR_RANGE  = 2'd2
    } fill_outcome_e;
endpackage

// File: rtl/fwb_fill.sv
// Buffer fill engine: holds the buffer words, the length, the bytes-written
// count and the captured base. Decides per write whether it is stored.
// Assumes setup and a data write are not used together. If they are, setup
// wins and the write is answered as ended.
module fwb_fill
    import flash_wrbuf_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int WAW       = 6,
    parameter int CNT_W     = 8,
    parameter int LEN_W     = 7,
    parameter int BUF_WORDS = 16,
    localparam int BIX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
    localparam int RQ_W     = CNT_W + 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        setup_valid,
    input  logic [CNT_W-1:0]            setup_count,
    input  logic                        wr_valid,
    input  logic [WAW-1:0]              wr_waddr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [UNIT_BYTES-1:0]       wr_be,
    output logic                        wr_ack,
    output logic                        wr_end,
    output logic [WAW-1:0]              base_w,
    output logic [LEN_W-1:0]            bytes_q,
    output logic [BUF_WORDS*DATA_W-1:0] buf_flat
);
    logic [DATA_W-1:0] buf_mem [BUF_WORDS];
    logic [LEN_W-1:0]  len_q;
    logic [RQ_W-1:0]   req_len;
    logic [LEN_W-1:0]  len_clamped;
    logic [WAW-1:0]    diff;
    logic [BIX_W-1:0]  slot;
    logic              capture;
    fill_outcome_e     outcome;

    // Requested length in bytes, clamped to the buffer size
    assign req_len     = (RQ_W'(setup_count) + RQ_W'(1)) << 2;
    assign len_clamped = (req_len > RQ_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : LEN_W'(req_len);

    // Classify the incoming write and pick its buffer slot
    always_comb begin
        diff    = wr_waddr - base_w;
        capture = (bytes_q == '0);
        slot    = '0;
        if (bytes_q >= len_q) begin
            outcome = WR_FULL;
        end else if (capture) begin
            outcome = WR_STORED;
        end else if ((wr_waddr < base_w) || (diff >= WAW'(BUF_WORDS))) begin
            outcome = WR_RANGE;
        end else begin
            outcome = WR_STORED;
            slot    = diff[BIX_W-1:0];
        end
    end

    // Setup clears the buffer; a stored write merges its enabled bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            bytes_q <= '0;
            base_w  <= '0;
            wr_ack  <= 1'b0;
            wr_end  <= 1'b0;
            for (int w = 0; w < BUF_WORDS; w++) buf_mem[w] <= '0;
        end else begin
            wr_ack <= wr_valid;
            wr_end <= wr_valid && (setup_valid || (outcome != WR_STORED));
            if (setup_valid) begin
                len_q   <= len_clamped;
                bytes_q <= '0;
                for (int w = 0; w < BUF_WORDS; w++) buf_mem[w] <= '0;
            end else if (wr_valid && (outcome == WR_STORED)) begin
                if (capture) base_w <= wr_waddr;
                bytes_q <= bytes_q + LEN_W'(UNIT_BYTES);
                for (int b = 0; b < UNIT_BYTES; b++) begin
                    if (wr_be[b]) buf_mem[slot][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Flatten the buffer for the array copy path
    for (genvar g = 0; g < BUF_WORDS; g++) begin : g_flat
        assign buf_flat[g*DATA_W +: DATA_W] = buf_mem[g];
    end
endmodule

// File: rtl/fwb_locks.sv
// Lock bit register: one bit per erase block, written by a strobe and
// read combinationally for the commit decision.
// Assumes the block count is a power of two.
module fwb_locks #(
    parameter int NBLK  = 4,
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [BLK_W-1:0] lock_blk,
    input  logic             lock_val,
    input  logic [BLK_W-1:0] query_blk,
    output logic             query_locked
);
    logic [NBLK-1:0] lock_bits;

    // Update one lock bit per strobe; all clear after reset
    always_ff @(posedge clk) begin
        if (!rst_n) lock_bits <= '0;
        else if (lock_we) lock_bits[lock_blk] <= lock_val;
    end

    assign query_locked = lock_bits[query_blk];
endmodule

// File: rtl/fwb_array.sv
// Array model: word storage that starts erased (all ones). It takes the
// whole buffer copy in one cycle and has a registered read port.
// Assumes the commit enable is already qualified by the lock check.
module fwb_array
    import flash_wrbuf_pkg::*;
#(
    parameter int ARRAY_WORDS = 64,
    parameter int WAW         = 6,
    parameter int BUF_WORDS   = 16,
    parameter int LEN_W       = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_en,
    input  logic [WAW-1:0]              base_w,
    input  logic [LEN_W-1:0]            bytes_q,
    input  logic [BUF_WORDS*DATA_W-1:0] buf_flat,
    input  logic [WAW-1:0]              rd_waddr,
    output logic [DATA_W-1:0]           rd_data
);
    logic [DATA_W-1:0] mem [ARRAY_WORDS];

    // Copy the written part of the buffer starting at the base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < ARRAY_WORDS; w++) mem[w] <= '1;
        end else if (commit_en) begin
            for (int i = 0; i < BUF_WORDS; i++) begin
                if ((int'(bytes_q) > i * UNIT_BYTES) && (int'(base_w) + i < ARRAY_WORDS))
                    mem[WAW'(int'(base_w) + i)] <= buf_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    // Registered read of one array word
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '1;
        else rd_data <= mem[rd_waddr];
    end
endmodule

// File: rtl/flash_wrbuf.sv
// Flash program write buffer top: fill engine, lock bits and array model,
// with the registered commit answer.
// Assumes ARRAY_BYTES, BLOCK_BYTES and MAX_BYTES are powers of two, with
// MAX_BYTES below ARRAY_BYTES and BLOCK_BYTES below ARRAY_BYTES.
module flash_wrbuf
    import flash_wrbuf_pkg::*;
#(
    parameter int MAX_BYTES    = 64,
    parameter int ARRAY_BYTES  = 256,
    parameter int BLOCK_BYTES  = 64,
    parameter int CNT_W        = 8,
    localparam int ARRAY_WORDS = ARRAY_BYTES / UNIT_BYTES,
    localparam int WAW         = $clog2(ARRAY_WORDS),
    localparam int BUF_WORDS   = MAX_BYTES / UNIT_BYTES,
    localparam int NBLK        = ARRAY_BYTES / BLOCK_BYTES,
    localparam int BLK_W       = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int LEN_W       = $clog2(MAX_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  setup_valid,
    input  logic [CNT_W-1:0]      setup_count,
    input  logic                  wr_valid,
    input  logic [WAW-1:0]        wr_waddr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [UNIT_BYTES-1:0] wr_be,
    output logic                  wr_ack,
    output logic                  wr_end,
    input  logic                  commit_valid,
    output logic                  commit_done,
    output logic                  commit_ok,
    input  logic                  lock_we,
    input  logic [BLK_W-1:0]      lock_blk,
    input  logic                  lock_val,
    input  logic [WAW-1:0]        rd_waddr,
    output logic [DATA_W-1:0]     rd_data
);
    logic [WAW-1:0]              base_w;
    logic [LEN_W-1:0]            bytes_q;
    logic [BUF_WORDS*DATA_W-1:0] buf_flat;
    logic [BLK_W-1:0]            base_blk;
    logic                        base_locked;
    logic                        commit_en;

    fwb_fill #(
        .MAX_BYTES(MAX_BYTES), .WAW(WAW), .CNT_W(CNT_W),
        .LEN_W(LEN_W), .BUF_WORDS(BUF_WORDS)
    ) fill_i (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_count(setup_count),
        .wr_valid(wr_valid), .wr_waddr(wr_waddr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ack(wr_ack), .wr_end(wr_end),
        .base_w(base_w), .bytes_q(bytes_q), .buf_flat(buf_flat)
    );

    // Erase block of the base: upper word-address bits
    assign base_blk = base_w[WAW-1 -: BLK_W];

    fwb_locks #(.NBLK(NBLK), .BLK_W(BLK_W)) locks_i (
        .clk(clk), .rst_n(rst_n),
        .lock_we(lock_we), .lock_blk(lock_blk), .lock_val(lock_val),
        .query_blk(base_blk), .query_locked(base_locked)
    );

    assign commit_en = commit_valid && !base_locked;

    fwb_array #(
        .ARRAY_WORDS(ARRAY_WORDS), .WAW(WAW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)
    ) array_i (
        .clk(clk), .rst_n(rst_n),
        .commit_en(commit_en), .base_w(base_w), .bytes_q(bytes_q), .buf_flat(buf_flat),
        .rd_waddr(rd_waddr), .rd_data(rd_data)
    );

    // Registered commit answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_done <= 1'b0;
            commit_ok   <= 1'b0;
        end else begin
            commit_done <= commit_valid;
            commit_ok   <= commit_en;
        end
    end
endmodule

// File: rtl/flash_wrbuf_chk.sv
// Protocol checker for the flash write buffer, bound to every instance.
// Assumes the synchronous active-low reset of the block.
module flash_wrbuf_chk #(
    parameter int WAW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_valid,
    input logic           wr_ack,
    input logic           wr_end,
    input logic           commit_valid,
    input logic           commit_done,
    input logic           commit_ok,
    input logic [WAW-1:0] rd_waddr,
    input logic [31:0]    rd_data
);
    // R4
    wr_ack_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_ack);
    // R4
    wr_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !wr_ack);
    // R6
    wr_end_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |-> wr_ack);
    // R8
    commit_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> commit_done);
    // R8
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_valid |=> !commit_done);
    // R9
    commit_ok_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> commit_done);
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit_valid) && $stable(rd_waddr)) |=> $stable(rd_data));
endmodule

bind flash_wrbuf flash_wrbuf_chk #(.WAW(WAW)) chk_i (.*);

// File: tb/flash_wrbuf_tb.sv
`timescale 1ns/100ps
// Bench for the flash write buffer: directed corners plus seeded random
// fills, compared against a model built from the requirements.
module flash_wrbuf_tb_top;
    localparam int MAXB = 64;
    localparam int BUFW = MAXB / 4;
    localparam int ARRW = 64;
    localparam int BLKW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [7:0]  setup_count = '0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_waddr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_ack, wr_end;
    logic        commit_valid = 1'b0;
    logic        commit_done, commit_ok;
    logic        lock_we = 1'b0;
    logic [1:0]  lock_blk = '0;
    logic        lock_val = 1'b0;
    logic [5:0]  rd_waddr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    // model state
    int          m_len = 0, m_bytes = 0, m_base = 0;
    logic [31:0] m_buf [BUFW];
    logic [31:0] m_arr [ARRW];
    bit          m_lock [4];

    always #2.5 clk = ~clk;

    flash_wrbuf dut_i (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_count(setup_count),
        .wr_valid(wr_valid), .wr_waddr(wr_waddr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ack(wr_ack), .wr_end(wr_end),
        .commit_valid(commit_valid), .commit_done(commit_done), .commit_ok(commit_ok),
        .lock_we(lock_we), .lock_blk(lock_blk), .lock_val(lock_val),
        .rd_waddr(rd_waddr), .rd_data(rd_data)
    );

    function automatic int exp_len(input int c);
        int l;
        l = (c + 1) * 4;
        if (l > MAXB) l = MAXB;
        return l;
    endfunction

    function automatic logic [31:0] merged(input logic [31:0] old, input logic [31:0] d,
                                           input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic do_setup(input int c);
        m_len = exp_len(c);
        m_bytes = 0;
        for (int i = 0; i < BUFW; i++) m_buf[i] = '0;
        @(negedge clk); setup_valid = 1'b1; setup_count = c[7:0];
        @(negedge clk); setup_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be,
                            input string req);
        bit e;
        e = 1'b0;
        if (m_bytes >= m_len) e = 1'b1;
        else if (m_bytes == 0) begin
            m_base = a; m_buf[0] = merged(m_buf[0], d, be); m_bytes += 4;
        end else if (a < m_base || a - m_base >= BUFW) e = 1'b1;
        else begin
            m_buf[a - m_base] = merged(m_buf[a - m_base], d, be); m_bytes += 4;
        end
        @(negedge clk); wr_valid = 1'b1; wr_waddr = a[5:0]; wr_data = d; wr_be = be;
        @(negedge clk); wr_valid = 1'b0;
        chk(wr_ack === 1'b1, {req, " ack"}, 32'(wr_ack), 32'd1);
        chk(wr_end === e, {req, " end"}, 32'(wr_end), 32'(e));
    endtask

    task automatic do_commit(input string req);
        bit ok;
        ok = !m_lock[m_base / BLKW];
        if (ok)
            for (int i = 0; i < BUFW; i++)
                if (m_bytes > i * 4 && m_base + i < ARRW) m_arr[m_base + i] = m_buf[i];
        @(negedge clk); commit_valid = 1'b1;
        @(negedge clk); commit_valid = 1'b0;
        chk(commit_done === 1'b1, {req, " done"}, 32'(commit_done), 32'd1);
        chk(commit_ok === ok, {req, " ok"}, 32'(commit_ok), 32'(ok));
    endtask

    task automatic do_lock(input int blk, input bit v);
        m_lock[blk] = v;
        @(negedge clk); lock_we = 1'b1; lock_blk = blk[1:0]; lock_val = v;
        @(negedge clk); lock_we = 1'b0;
    endtask

    task automatic check_word(input int w, input string req);
        @(negedge clk); rd_waddr = w[5:0];
        @(negedge clk);
        chk(rd_data === m_arr[w], req, rd_data, m_arr[w]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < ARRW; i++) m_arr[i] = '1;
        for (int i = 0; i < BUFW; i++) m_buf[i] = '0;
        for (int i = 0; i < 4; i++) m_lock[i] = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_word(0, "R1 erased array");
        check_word(63, "R1 erased array");
        do_write(5, 32'h1111_2222, 4'hF, "R1 zero length");
        do_commit("R1 no lock");

        // R2/R4/R5/R6: short fill of 8 bytes
        do_setup(1);
        do_write(10, 32'hA0A0_0001, 4'hF, "R4 base capture");
        do_write(11, 32'hA0A0_0002, 4'hF, "R5 offset store");
        do_write(12, 32'hA0A0_0003, 4'hF, "R6 full");
        do_commit("R9 commit");
        check_word(10, "R9 word 0");
        check_word(11, "R9 word 1");
        check_word(12, "R6 dropped word");

        // R2: clamp to buffer size
        do_setup(100);
        for (int k = 0; k < BUFW; k++) do_write(20 + k, 32'hC000_0000 + k, 4'hF, "R2 clamped");
        do_write(20, 32'hDEAD_BEEF, 4'hF, "R2 clamp end");

        // R3/R5: buffer cleared, byte enables
        do_setup(3);
        do_write(40, 32'h1234_5678, 4'b0001, "R3 partial");
        do_write(41, 32'h1234_5678, 4'b1111, "R5 full word");
        do_write(41, 32'hAABB_CCDD, 4'b0100, "R5 merge");
        do_commit("R9 commit");
        check_word(40, "R3 zeroed bytes");
        check_word(41, "R5 byte enable");

        // R7: range checks
        do_setup(7);
        do_write(30, 32'h3000_0000, 4'hF, "R7 base");
        do_write(29, 32'h2900_0000, 4'hF, "R7 below base");
        do_write(46, 32'h4600_0000, 4'hF, "R7 beyond window");
        do_write(45, 32'h4500_0000, 4'hF, "R7 last slot");
        do_commit("R9 commit");
        check_word(45, "R7 last slot data");
        check_word(29, "R7 untouched");

        // R8/R10: locked block refuses, unlock allows
        do_lock(1, 1'b1);
        do_setup(0);
        do_write(18, 32'h1818_1818, 4'hF, "R8 write");
        do_commit("R8 locked");
        check_word(18, "R8 array unchanged");
        do_lock(1, 1'b0);
        do_commit("R10 unlocked");
        check_word(18, "R10 array updated");

        // R9: copy clipped at array end, repeated slot counts twice
        do_setup(2);
        do_write(62, 32'h6262_6262, 4'hF, "R9 end base");
        do_write(62, 32'h6363_6363, 4'h3, "R9 rewrite");
        do_write(62, 32'h6464_6464, 4'hF, "R9 rewrite");
        do_commit("R9 clipped");
        check_word(62, "R9 end word");
        check_word(63, "R9 zero copy");

        // Random fills
        for (int it = 0; it < 25; it++) begin
            int n, first, a;
            do_setup($urandom_range(0, 20));
            n = $urandom_range(0, 20);
            first = $urandom_range(0, 63);
            for (int k = 0; k < n; k++) begin
                a = (k == 0) ? first : first + $urandom_range(0, 22) - 3;
                if (a < 0) a = 0;
                if (a > 63) a = 63;
                do_write(a, $urandom, 4'($urandom_range(0, 15)), "R5 random");
            end
            if ($urandom_range(0, 2) == 0) do_lock($urandom_range(0, 3), 1'($urandom_range(0, 1)));
            do_commit("R9 random");
            if (it % 5 == 4) begin
                for (int w = 0; w < ARRW; w++) check_word(w, "R11 array scan");
            end else begin
                for (int w = m_base; w < m_base + BUFW && w < ARRW; w++) check_word(w, "R9 random copy");
            end
        end

        summary();
        $finish;
    end
endmodule